// File: doc/BRIEF.md
# Reset Boot Area Selector

This block decides which memory is aliased at address zero once reset ends. It can pick main flash, system memory (the bootloader) or embedded SRAM. The decision uses the boot pin level taken when the external reset pin rises, a lock bit, three option bits, a flag that says the flash is blank, and a sticky override that is set when a debugger uses the boot pin. The choice is taken on a fixed system clock edge after system reset is released. It is taken again when the chip leaves a low-power mode. The CPU fetch logic reads the result from `boot_area` when `boot_valid` pulses.

The block also keeps the blank-flash flag. The option-load sequencer presents the first flash word with `obl_valid`. The flag is set when every bit of that word, check bits included, reads as one, and cleared otherwise. Software may also write the flag. All pins are plain control and status signals: there is no streaming data path, so no handshake or back-pressure applies.

Top module: `boot_area_select`

## Requirements
- R1: The boot pin is captured on the first clock edge that sees `ext_rst_n` high after it was low, and on each `lp_exit` pulse. Changes on `boot0_pin` at other times do not affect the selected area.
- R2: After `sys_rst_n` is released, the area is latched on the 4th rising clock edge (parameter LATCH_EDGE). `boot_valid` is high for exactly one cycle after that edge and `boot_area` changes only then. The encoding is 00 main flash, 01 system memory, 11 SRAM, and 10 never appears. In reset, `boot_area` is 00 and `boot_valid` is 0.
- R3: When `opt_lock` is 1, main flash (00) is selected whatever the other inputs are, the blank flag included.
- R4: When `opt_lock`=0 and `opt_nboot_sel`=0, the captured pin acts as boot bit: 0 gives main flash, and 1 gives system memory if `opt_nboot1`=1 or SRAM if `opt_nboot1`=0.
- R5: When `opt_lock`=0 and `opt_nboot_sel`=1, the inverse of `opt_nboot0` acts as boot bit: `opt_nboot0`=1 gives main flash, and `opt_nboot0`=0 picks system memory or SRAM from `opt_nboot1` as in R4.
- R6: If the rules above give main flash with the lock clear and `empty_flag`=1, system memory (01) is selected instead. SRAM and system memory choices are not affected.
- R7: When `obl_valid` is high, `empty_flag` becomes 1 if `obl_word` is all ones and 0 otherwise, on the next edge. Only `por_n` clears it by reset. `sys_rst_n` leaves it unchanged.
- R8: When `sw_empty_we` is high, `empty_flag` takes `sw_empty_wdata`. If `obl_valid` is high in the same cycle, the option-load value wins.
- R9: A `dbg_access` pulse while `opt_nboot_sel`=0 forces the pin boot bit to 0 from then on. The override survives `sys_rst_n` and is cleared only by `por_n`.
- R10: An `lp_exit` pulse re-captures the pin, restarts the count, and latches the area again on the 4th edge after the pulse, using the inputs current at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset, asynchronous, active low |
| ext_rst_n | input | 1 | External reset pin level, synchronous to clk |
| boot0_pin | input | 1 | Boot pin level |
| opt_lock | input | 1 | Boot lock bit: forces main flash |
| opt_nboot1 | input | 1 | Option bit choosing system memory (1) or SRAM (0) |
| opt_nboot_sel | input | 1 | Option bit: 1 takes the boot bit from options instead of the pin |
| opt_nboot0 | input | 1 | Inverted option boot bit |
| dbg_access | input | 1 | Debugger access detected |
| lp_exit | input | 1 | Exit from standby or shutdown, one-cycle pulse |
| obl_valid | input | 1 | Option load presents the first flash word |
| obl_word | input | FLASH_WORD_W | First flash word including check bits |
| sw_empty_we | input | 1 | Software write strobe for the blank flag |
| sw_empty_wdata | input | 1 | Software write value for the blank flag |
| boot_area | output | 2 | Selected area: 00 flash, 01 system memory, 11 SRAM |
| boot_valid | output | 1 | One-cycle strobe when the area is latched |
| empty_flag | output | 1 | Blank-flash flag |

## Verification
On every cycle the assertions check these rules: the strobe lasts one cycle, the area holds between strobes, the 10 code never appears, a lock at the latch edge always yields flash, the blank flag follows each option-load word, and the debugger override never clears without a power-on reset. Other behaviour only the bench scenarios can show. This covers the exact edge on which the area is latched after reset or low-power exit, that the pin is held from the reset rising edge, the full decode table with the blank-flash fallback, the priority between software writes and option loads, and that the override and blank flag both survive a system reset.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

  typedef enum logic [1:0] {
    AREA_FLASH  = 2'b00,
    AREA_SYSMEM = 2'b01,
    AREA_SRAM   = 2'b11
  } area_t;

  // Boot area decode: lock override, pin/option boot bit, blank fallback.
  function automatic area_t decode_area(
    input logic lock,
    input logic nboot_sel,
    input logic nboot0,
    input logic nboot1,
    input logic pin_bit,
    input logic empty
  );
    logic boot_bit;
    area_t area;
    if (lock) begin
      area = AREA_FLASH;
    end else begin
      boot_bit = nboot_sel ? ~nboot0 : pin_bit;
      if (!boot_bit) area = empty ? AREA_SYSMEM : AREA_FLASH;
      else           area = nboot1 ? AREA_SYSMEM : AREA_SRAM;
    end
    return area;
  endfunction

endpackage

// File: rtl/boot_pin_capture.sv
module boot_pin_capture (
  input  logic clk,
  input  logic por_n,
  input  logic ext_rst_n,
  input  logic boot0_pin,
  input  logic lp_exit,
  input  logic dbg_access,
  input  logic nboot_sel,
  output logic pin_bit,
  output logic dbg_force
);

  logic ext_prev_q;
  logic pin_q;
  logic force_q;
  logic ext_rise;

  assign ext_rise = ext_rst_n && !ext_prev_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ext_prev_q <= 1'b0;
      pin_q      <= 1'b0;
    end else begin
      ext_prev_q <= ext_rst_n;
      if (ext_rise || lp_exit) pin_q <= boot0_pin;
    end
  end

  // Sticky override: only a power-on reset clears it.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) force_q <= 1'b0;
    else if (dbg_access && !nboot_sel) force_q <= 1'b1;
  end

  assign pin_bit   = pin_q && !force_q;
  assign dbg_force = force_q;

endmodule

// File: rtl/boot_empty_flag.sv
module boot_empty_flag #(
  parameter int FLASH_WORD_W = 72
) (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    obl_valid,
  input  logic [FLASH_WORD_W-1:0] obl_word,
  input  logic                    sw_we,
  input  logic                    sw_wdata,
  output logic                    empty
);

  logic word_blank;
  logic empty_q;

  assign word_blank = &obl_word;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          empty_q <= 1'b0;
    else if (obl_valid)  empty_q <= word_blank;
    else if (sw_we)      empty_q <= sw_wdata;
  end

  assign empty = empty_q;

endmodule

// File: rtl/boot_latch_timer.sv
module boot_latch_timer #(
  parameter int LATCH_EDGE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic fire
);

  localparam int CNT_W = $clog2(LATCH_EDGE + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LATCH_EDGE - 1);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(LATCH_EDGE);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (restart)       cnt_q <= '0;
    else if (cnt_q != DONE) cnt_q <= cnt_q + 1'b1;
  end

  // The edge that moves the count from LAST to DONE is the latch edge.
  assign fire = (cnt_q == LAST) && !restart;

endmodule

// File: rtl/boot_area_select.sv
module boot_area_select
  import boot_sel_pkg::*;
#(
  parameter int LATCH_EDGE   = 4,
  parameter int FLASH_WORD_W = 72
) (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    sys_rst_n,
  input  logic                    ext_rst_n,
  input  logic                    boot0_pin,
  input  logic                    opt_lock,
  input  logic                    opt_nboot1,
  input  logic                    opt_nboot_sel,
  input  logic                    opt_nboot0,
  input  logic                    dbg_access,
  input  logic                    lp_exit,
  input  logic                    obl_valid,
  input  logic [FLASH_WORD_W-1:0] obl_word,
  input  logic                    sw_empty_we,
  input  logic                    sw_empty_wdata,
  output logic [1:0]              boot_area,
  output logic                    boot_valid,
  output logic                    empty_flag
);

  logic  pin_bit;
  logic  dbg_force;
  logic  fire;
  area_t next_area;
  area_t area_q;
  logic  valid_q;

  boot_pin_capture u_pin (
    .clk        (clk),
    .por_n      (por_n),
    .ext_rst_n  (ext_rst_n),
    .boot0_pin  (boot0_pin),
    .lp_exit    (lp_exit),
    .dbg_access (dbg_access),
    .nboot_sel  (opt_nboot_sel),
    .pin_bit    (pin_bit),
    .dbg_force  (dbg_force)
  );

  boot_empty_flag #(.FLASH_WORD_W(FLASH_WORD_W)) u_empty (
    .clk       (clk),
    .por_n     (por_n),
    .obl_valid (obl_valid),
    .obl_word  (obl_word),
    .sw_we     (sw_empty_we),
    .sw_wdata  (sw_empty_wdata),
    .empty     (empty_flag)
  );

  boot_latch_timer #(.LATCH_EDGE(LATCH_EDGE)) u_timer (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .restart (lp_exit),
    .fire    (fire)
  );

  always_comb begin
    next_area = decode_area(opt_lock, opt_nboot_sel, opt_nboot0,
                            opt_nboot1, pin_bit, empty_flag);
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      area_q  <= AREA_FLASH;
      valid_q <= 1'b0;
    end else begin
      valid_q <= fire;
      if (fire) area_q <= next_area;
    end
  end

  assign boot_area  = area_q;
  assign boot_valid = valid_q;

endmodule

// File: rtl/boot_area_select_chk.sv
module boot_area_select_chk #(
  parameter int FLASH_WORD_W = 72
) (
  input logic                    clk,
  input logic                    por_n,
  input logic                    sys_rst_n,
  input logic                    opt_lock,
  input logic                    obl_valid,
  input logic [FLASH_WORD_W-1:0] obl_word,
  input logic [1:0]              boot_area,
  input logic                    boot_valid,
  input logic                    empty_flag,
  input logic                    dbg_force
);

  // R2: strobe lasts one cycle
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_n)
    boot_valid |=> !boot_valid);

  // R2: area moves only with the strobe
  a_r2_area_hold: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_n)
    !boot_valid |-> $stable(boot_area));

  // R2: code 10 is never produced
  a_r2_legal_code: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_n)
    boot_area != 2'b10);

  // R3: lock at the latch edge gives main flash
  a_r3_lock_flash: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_n)
    (boot_valid && $past(opt_lock)) |-> boot_area == 2'b00);

  // R7: flag follows each option-load word
  a_r7_empty_load: assert property (@(posedge clk) disable iff (!por_n)
    $past(obl_valid) |-> empty_flag == (&$past(obl_word)));

  // R9: override never drops without power-on reset
  a_r9_force_sticky: assert property (@(posedge clk) disable iff (!por_n)
    $past(dbg_force) |-> dbg_force);

endmodule

bind boot_area_select boot_area_select_chk #(.FLASH_WORD_W(FLASH_WORD_W)) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .sys_rst_n  (sys_rst_n),
  .opt_lock   (opt_lock),
  .obl_valid  (obl_valid),
  .obl_word   (obl_word),
  .boot_area  (boot_area),
  .boot_valid (boot_valid),
  .empty_flag (empty_flag),
  .dbg_force  (dbg_force)
);

// File: tb/tb_boot_area_select.sv
module tb_boot_area_select;

  localparam int W = 72;
  localparam logic [1:0] FL = 2'b00, SM = 2'b01, SR = 2'b11;

  logic clk = 1'b0;
  logic por_n, sys_rst_n, ext_rst_n, boot0_pin;
  logic opt_lock, opt_nboot1, opt_nboot_sel, opt_nboot0;
  logic dbg_access, lp_exit, obl_valid, sw_empty_we, sw_empty_wdata;
  logic [W-1:0] obl_word;
  logic [1:0] boot_area;
  logic boot_valid, empty_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  boot_area_select #(.LATCH_EDGE(4), .FLASH_WORD_W(W)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_opts(input logic lk, input logic sel, input logic nb0,
                          input logic nb1, input logic pin);
    opt_lock = lk; opt_nboot_sel = sel; opt_nboot0 = nb0;
    opt_nboot1 = nb1; boot0_pin = pin;
  endtask

  // Apply reset, release on a falling edge, check the latch edge and area.
  task automatic boot(input logic por, input logic [1:0] exp, input string req);
    @(negedge clk);
    sys_rst_n = 0; ext_rst_n = 0;
    if (por) por_n = 0;
    repeat (3) @(negedge clk);
    por_n = 1; sys_rst_n = 1; ext_rst_n = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 no strobe before 4th edge", boot_valid, 0);
    end
    @(negedge clk);
    chk("R2 strobe on 4th edge", boot_valid, 1);
    chk(req, boot_area, exp);
    @(negedge clk);
    chk("R2 strobe one cycle", boot_valid, 0);
    chk("R2 area held", boot_area, exp);
  endtask

  task automatic load_word(input logic [W-1:0] w);
    @(negedge clk); obl_valid = 1; obl_word = w;
    @(negedge clk); obl_valid = 0;
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    chk("R2 reset area", boot_area, 0);
    chk("R2 reset strobe", boot_valid, 0);
    chk("R7 reset empty", empty_flag, 0);
  endtask

  task automatic t_pin_decode;
    set_opts(0, 0, 0, 1, 0); boot(0, FL, "R4 pin0 flash");
    set_opts(0, 0, 0, 1, 1); boot(0, SM, "R4 pin1 nboot1=1 sysmem");
    set_opts(0, 0, 0, 0, 1); boot(0, SR, "R4 pin1 nboot1=0 sram");
  endtask

  task automatic t_opt_decode;
    set_opts(0, 1, 1, 0, 1); boot(0, FL, "R5 nboot0=1 flash, pin ignored");
    set_opts(0, 1, 0, 1, 0); boot(0, SM, "R5 nboot0=0 sysmem");
    set_opts(0, 1, 0, 0, 0); boot(0, SR, "R5 nboot0=0 sram");
  endtask

  task automatic t_lock;
    set_opts(1, 0, 0, 0, 1); boot(0, FL, "R3 lock over pin");
    set_opts(1, 1, 0, 1, 0); boot(0, FL, "R3 lock over options");
  endtask

  task automatic t_pin_capture;
    // R1: pin dropped after the capture edge must not change the choice
    set_opts(0, 0, 0, 1, 1);
    @(negedge clk); sys_rst_n = 0; ext_rst_n = 0;
    repeat (2) @(negedge clk);
    sys_rst_n = 1; ext_rst_n = 1;
    @(negedge clk); boot0_pin = 0;
    repeat (3) @(negedge clk);
    chk("R1 strobe", boot_valid, 1);
    chk("R1 pin held from reset rise", boot_area, SM);
  endtask

  task automatic t_empty;
    load_word('1);
    chk("R7 all ones sets flag", empty_flag, 1);
    set_opts(0, 0, 0, 0, 0); boot(0, SM, "R6 blank flash falls back to sysmem");
    chk("R7 sys reset keeps flag", empty_flag, 1);
    set_opts(0, 1, 0, 0, 0); boot(0, SR, "R6 sram unaffected by flag");
    set_opts(1, 0, 0, 0, 0); boot(0, FL, "R3 lock ignores blank flag");
    load_word({1'b0, {(W-1){1'b1}}});
    chk("R7 one zero bit clears flag", empty_flag, 0);
    // R8: software write, then simultaneous write loses to option load
    @(negedge clk); sw_empty_we = 1; sw_empty_wdata = 1;
    @(negedge clk); sw_empty_we = 0;
    chk("R8 sw write sets flag", empty_flag, 1);
    @(negedge clk); sw_empty_we = 1; sw_empty_wdata = 0; obl_valid = 1; obl_word = '1;
    @(negedge clk); sw_empty_we = 0; obl_valid = 0;
    chk("R8 option load wins", empty_flag, 1);
    @(negedge clk); sw_empty_we = 1; sw_empty_wdata = 0;
    @(negedge clk); sw_empty_we = 0;
    chk("R8 sw write clears flag", empty_flag, 0);
  endtask

  task automatic t_debug;
    set_opts(0, 1, 1, 1, 1);
    @(negedge clk); dbg_access = 1;
    @(negedge clk); dbg_access = 0;
    set_opts(0, 0, 0, 1, 1); boot(0, SM, "R9 no override when options select");
    @(negedge clk); dbg_access = 1;
    @(negedge clk); dbg_access = 0;
    boot(0, FL, "R9 override forces boot bit low");
    boot(0, FL, "R9 override survives system reset");
    boot(1, SM, "R9 power-on reset clears override");
  endtask

  task automatic t_lp_exit;
    set_opts(0, 0, 0, 1, 0); boot(0, FL, "R10 pre-exit flash");
    set_opts(0, 0, 0, 0, 1);
    @(negedge clk); lp_exit = 1;
    @(negedge clk); lp_exit = 0;
    boot0_pin = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 no strobe before 4th edge", boot_valid, 0);
      chk("R10 old area held", boot_area, FL);
    end
    @(negedge clk);
    chk("R10 strobe on 4th edge", boot_valid, 1);
    chk("R10 re-captured pin gives sram", boot_area, SR);
  endtask

  initial begin
    por_n = 0; sys_rst_n = 0; ext_rst_n = 0;
    set_opts(0, 0, 0, 0, 0);
    dbg_access = 0; lp_exit = 0; obl_valid = 0; obl_word = '0;
    sw_empty_we = 0; sw_empty_wdata = 0;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_pin_decode();
    t_opt_decode();
    t_lock();
    t_pin_capture();
    t_empty();
    t_debug();
    t_lp_exit();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule